// File: doc/BRIEF.md
# Completion Queue Entry Poster

This block sits on the controller side of a host/controller storage queue pair. Finished commands arrive as records from any number of submission queues. Each record names its source queue, that queue's current head, the command identifier, a status code and a one-dword result. The block turns each record into a 16-byte completion entry and writes it into a single circular completion queue in host memory. Each write goes to the slot after the previous one. After each write is accepted, the block raises a one-cycle interrupt request.

The tail pointer exists only inside the block, and the host never reads it. Instead, every entry carries a phase bit. This bit is 1 on the first pass through the ring and inverts on each wrap, so a polling host can tell a fresh entry from a stale one. The host gives consumed slots back by writing its new head index to a doorbell input. A doorbell value outside the ring is dropped and latches an error flag. When the ring is full, the block stops accepting records until the host frees space. Entries are posted in the order records are accepted. No reordering by command identifier is done.

Top module: `cq_poster`

## Requirements
- R1: After reset, `memReq`, `irqPulse` and `dbError` are 0 and `cmpReady` is 1; the ring starts empty at slot 0 with phase 1.
- R2: The entry written on `memData` holds the result in bits 127:96, zero in bits 95:64, the submission queue ID in bits 63:48, the submission queue head in bits 47:32, the command identifier in bits 31:16, the status in bits 15:1 and the phase bit in bit 0.
- R3: Entries go to consecutive slots starting at slot 0 after configuration. A slot's byte address is `cfgBase + 16*slot`, and after slot DEPTH-1 the next slot is 0.
- R4: The phase bit is 1 for entries written on the first pass after configuration. It inverts each time the tail wraps from slot DEPTH-1 to slot 0.
- R5: Once `memReq` is raised, it stays high with `memAddr` and `memData` unchanged until a cycle in which `memGnt` is high.
- R6: `irqPulse` is high for exactly one cycle, the cycle after the cycle in which `memReq` and `memGnt` are both high.
- R7: The ring is full when (tail+1) mod DEPTH equals the head. While it is full, `cmpReady` is 0, so at most DEPTH-1 entries are outstanding.
- R8: A doorbell write with a value below DEPTH sets the head to that value. `cmpReady` reflects the freed space in the next cycle.
- R9: A doorbell value of DEPTH or more leaves the head unchanged and sets `dbError`. `dbError` stays set until the next configuration.
- R10: A `cfgInit` pulse latches `cfgBase`, sets the tail and head to slot 0 and the phase to 1, and clears `dbError`.
- R11: Only one entry is in flight at a time. A record is accepted when `cmpValid` and `cmpReady` are both high. `memReq` rises in the next cycle, and `cmpReady` stays 0 while `memReq` is high.
- R12: A doorbell write in the same cycle as a granted memory write applies both the head update and the tail advance. The next cycle's `cmpReady` reflects both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgInit | input | 1 | One-cycle pulse that sets up the ring |
| cfgBase | input | ADDR_W | Ring base byte address, taken on `cfgInit` |
| cmpValid | input | 1 | Completion record valid |
| cmpReady | output | 1 | Block can accept a record |
| cmpSqId | input | 16 | Source submission queue ID |
| cmpSqHead | input | 16 | Source submission queue head |
| cmpCid | input | 16 | Command identifier |
| cmpStatus | input | 15 | Completion status |
| cmpResult | input | 32 | Command-specific result dword |
| memReq | output | 1 | Memory write request |
| memGnt | input | 1 | Memory write accepted this cycle |
| memAddr | output | ADDR_W | Write byte address |
| memData | output | 128 | Completion entry |
| irqPulse | output | 1 | Interrupt request pulse |
| dbValid | input | 1 | Completion doorbell write strobe |
| dbHead | input | 16 | New head index from the host |
| dbError | output | 1 | Sticky flag for an out-of-range doorbell |

## Verification
The tail advance from a granted write and the head update from a doorbell can land on the same clock edge. Each alone would leave the full check with a different answer. The bench sets up a ring with one free slot and posts into it. It raises the doorbell in exactly the cycle it grants the write, so the ring would be full after the tail advance if the doorbell were lost. It then requires `cmpReady` to be high in the following cycle, with the next entry landing at the advanced slot.

// File: rtl/cq_pkg.sv
package cq_pkg;

  typedef struct packed {
    logic [31:0] result;
    logic [31:0] rsvd;
    logic [15:0] sqId;
    logic [15:0] sqHead;
    logic [15:0] cid;
    logic [14:0] status;
    logic        phase;
  } cqEntry_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;
    logic phase;
  } cqStrobe_t;

endpackage

// File: rtl/cq_ctrl.sv
module cq_ctrl
  import cq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgInit,
  input  logic             cmpValid,
  output logic             cmpReady,
  input  logic             memGnt,
  output logic             memReq,
  input  logic             dbValid,
  input  logic [15:0]      dbHead,
  output logic             dbError,
  output logic             irqPulse,
  output logic [PTR_W-1:0] tail,
  output cqStrobe_t        strobe
);

  logic [PTR_W-1:0] head;
  logic [PTR_W-1:0] nextTail;
  logic             phase;
  logic             busy;
  logic             full;
  logic             accept;
  logic             posted;
  logic             wrap;
  logic             dbInRange;

  assign wrap      = (tail == PTR_W'(DEPTH - 1));
  assign nextTail  = wrap ? '0 : tail + 1'b1;
  assign full      = (nextTail == head);
  assign cmpReady  = !busy && !full;
  assign accept    = cmpValid && cmpReady;
  assign posted    = busy && memGnt;
  assign memReq    = busy;
  assign dbInRange = ({16'd0, dbHead} < 32'(DEPTH));

  assign strobe.load  = accept;
  assign strobe.phase = phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail     <= '0;
      head     <= '0;
      phase    <= 1'b1;
      busy     <= 1'b0;
      dbError  <= 1'b0;
      irqPulse <= 1'b0;
    end else if (cfgInit) begin
      tail     <= '0;
      head     <= '0;
      phase    <= 1'b1;
      busy     <= 1'b0;
      dbError  <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      irqPulse <= posted;
      if (accept) begin
        busy <= 1'b1;
      end else if (posted) begin
        busy <= 1'b0;
      end
      if (posted) begin
        tail <= nextTail;
        if (wrap) phase <= ~phase;
      end
      if (dbValid) begin
        if (dbInRange) head <= dbHead[PTR_W-1:0];
        else           dbError <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cq_datapath.sv
module cq_datapath
  import cq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgInit,
  input  logic [ADDR_W-1:0] cfgBase,
  input  cqStrobe_t         strobe,
  input  logic [PTR_W-1:0]  tail,
  input  logic [15:0]       cmpSqId,
  input  logic [15:0]       cmpSqHead,
  input  logic [15:0]       cmpCid,
  input  logic [14:0]       cmpStatus,
  input  logic [31:0]       cmpResult,
  output logic [ADDR_W-1:0] memAddr,
  output logic [127:0]      memData
);

  localparam int SLOT_SHIFT = 4;

  logic [ADDR_W-1:0] baseQ;
  cqEntry_t          entryQ;
  logic [ADDR_W-1:0] addrQ;
  cqEntry_t          entryD;

  always_comb begin
    entryD.result = cmpResult;
    entryD.rsvd   = '0;
    entryD.sqId   = cmpSqId;
    entryD.sqHead = cmpSqHead;
    entryD.cid    = cmpCid;
    entryD.status = cmpStatus;
    entryD.phase  = strobe.phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseQ  <= '0;
      entryQ <= '0;
      addrQ  <= '0;
    end else begin
      if (cfgInit) baseQ <= cfgBase;
      if (strobe.load) begin
        entryQ <= entryD;
        addrQ  <= baseQ + (ADDR_W'(tail) << SLOT_SHIFT);
      end
    end
  end

  assign memAddr = addrQ;
  assign memData = entryQ;

endmodule

// File: rtl/cq_poster.sv
module cq_poster
  import cq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgInit,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic              cmpValid,
  output logic              cmpReady,
  input  logic [15:0]       cmpSqId,
  input  logic [15:0]       cmpSqHead,
  input  logic [15:0]       cmpCid,
  input  logic [14:0]       cmpStatus,
  input  logic [31:0]       cmpResult,
  output logic              memReq,
  input  logic              memGnt,
  output logic [ADDR_W-1:0] memAddr,
  output logic [127:0]      memData,
  output logic              irqPulse,
  input  logic              dbValid,
  input  logic [15:0]       dbHead,
  output logic              dbError
);

  localparam int PTR_W = $clog2(DEPTH);

  cqStrobe_t        strobe;
  logic [PTR_W-1:0] tail;

  cq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfgInit  (cfgInit),
    .cmpValid (cmpValid),
    .cmpReady (cmpReady),
    .memGnt   (memGnt),
    .memReq   (memReq),
    .dbValid  (dbValid),
    .dbHead   (dbHead),
    .dbError  (dbError),
    .irqPulse (irqPulse),
    .tail     (tail),
    .strobe   (strobe)
  );

  cq_datapath #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgInit   (cfgInit),
    .cfgBase   (cfgBase),
    .strobe    (strobe),
    .tail      (tail),
    .cmpSqId   (cmpSqId),
    .cmpSqHead (cmpSqHead),
    .cmpCid    (cmpCid),
    .cmpStatus (cmpStatus),
    .cmpResult (cmpResult),
    .memAddr   (memAddr),
    .memData   (memData)
  );

endmodule

// File: rtl/cq_poster_chk.sv
module cq_poster_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfgInit,
  input logic              cmpValid,
  input logic              cmpReady,
  input logic              memReq,
  input logic              memGnt,
  input logic [ADDR_W-1:0] memAddr,
  input logic [127:0]      memData,
  input logic              irqPulse,
  input logic              dbError
);

  // R5: a pending request holds its address and data
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n || cfgInit)
    (memReq && !memGnt) |=> (memReq && $stable(memAddr) && $stable(memData)));

  // R6: interrupt follows a granted write and lasts one cycle
  assert_irq_after_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqPulse) |-> $past(memReq && memGnt));
  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irqPulse |=> !irqPulse);

  // R11: one entry in flight
  assert_accept_issues_R11: assert property (@(posedge clk) disable iff (!rst_n || cfgInit)
    (cmpValid && cmpReady) |=> memReq);
  assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> !cmpReady);

  // R9: error flag is sticky until configuration
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbError && !cfgInit) |=> dbError);

  // R2: reserved dword is zero on every write
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> (memData[95:64] == 32'd0));

endmodule

bind cq_poster cq_poster_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfgInit  (cfgInit),
  .cmpValid (cmpValid),
  .cmpReady (cmpReady),
  .memReq   (memReq),
  .memGnt   (memGnt),
  .memAddr  (memAddr),
  .memData  (memData),
  .irqPulse (irqPulse),
  .dbError  (dbError)
);

// File: tb/cq_poster_tb.sv
module cq_poster_tb;

  localparam int DEPTH  = 8;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfgInit = 1'b0;
  logic [ADDR_W-1:0] cfgBase = '0;
  logic              cmpValid = 1'b0;
  logic              cmpReady;
  logic [15:0]       cmpSqId = '0;
  logic [15:0]       cmpSqHead = '0;
  logic [15:0]       cmpCid = '0;
  logic [14:0]       cmpStatus = '0;
  logic [31:0]       cmpResult = '0;
  logic              memReq;
  logic              memGnt = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic [127:0]      memData;
  logic              irqPulse;
  logic              dbValid = 1'b0;
  logic [15:0]       dbHead = '0;
  logic              dbError;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int          expTail;
  int          expHead;
  logic        expPhase;
  logic        expErr;
  logic [31:0] expBase;

  always #5 clk = ~clk;

  cq_poster #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfgInit(cfgInit), .cfgBase(cfgBase),
    .cmpValid(cmpValid), .cmpReady(cmpReady), .cmpSqId(cmpSqId),
    .cmpSqHead(cmpSqHead), .cmpCid(cmpCid), .cmpStatus(cmpStatus),
    .cmpResult(cmpResult), .memReq(memReq), .memGnt(memGnt),
    .memAddr(memAddr), .memData(memData), .irqPulse(irqPulse),
    .dbValid(dbValid), .dbHead(dbHead), .dbError(dbError)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit modelFull();
    return ((expTail + 1) % DEPTH) == expHead;
  endfunction

  task automatic configure(input logic [31:0] base);
    @(negedge clk);
    cfgInit = 1'b1;
    cfgBase = base;
    @(negedge clk);
    cfgInit = 1'b0;
    expTail = 0; expHead = 0; expPhase = 1'b1; expErr = 1'b0; expBase = base;
    chk("R10 error cleared", dbError, 1'b0);
    chk("R10 ready after init", cmpReady, 1'b1);
  endtask

  task automatic postOne(input logic [15:0] sid, input logic [15:0] sh,
                         input logic [15:0] cid, input logic [14:0] st,
                         input logic [31:0] res, input int gntDelay,
                         input bit dbAtGnt, input logic [15:0] dbVal);
    logic [127:0] expData;
    @(negedge clk);
    chk("R7 ready before post", cmpReady, 1'b1);
    cmpValid = 1'b1; cmpSqId = sid; cmpSqHead = sh; cmpCid = cid;
    cmpStatus = st; cmpResult = res;
    @(negedge clk);
    cmpValid = 1'b0;
    chk("R11 memReq after accept", memReq, 1'b1);
    chk("R11 ready low while busy", cmpReady, 1'b0);
    expData = {res, 32'd0, sid, sh, cid, st, expPhase};
    chk("R2 entry layout / R4 phase", memData, expData);
    chk("R3 slot address", memAddr, expBase + 32'(expTail * 16));
    for (int i = 0; i < gntDelay; i++) begin
      @(negedge clk);
      chk("R5 request held", memReq, 1'b1);
      chk("R5 data stable", memData, expData);
      chk("R6 no irq before grant", irqPulse, 1'b0);
    end
    memGnt = 1'b1;
    if (dbAtGnt) begin dbValid = 1'b1; dbHead = dbVal; end
    @(negedge clk);
    memGnt = 1'b0; dbValid = 1'b0;
    chk("R6 irq after grant", irqPulse, 1'b1);
    chk("R5 request dropped", memReq, 1'b0);
    if (expTail == DEPTH - 1) begin expTail = 0; expPhase = ~expPhase; end
    else expTail = expTail + 1;
    if (dbAtGnt) expHead = int'(dbVal);
    chk(dbAtGnt ? "R12 ready with same-cycle doorbell" : "R7 ready vs full",
        cmpReady, !modelFull());
    @(negedge clk);
    chk("R6 irq single cycle", irqPulse, 1'b0);
  endtask

  task automatic ringDb(input logic [15:0] val);
    @(negedge clk);
    dbValid = 1'b1; dbHead = val;
    @(negedge clk);
    dbValid = 1'b0;
    if (int'(val) < DEPTH) expHead = int'(val);
    else expErr = 1'b1;
    chk("R9 error flag", dbError, expErr);
    chk("R8 ready after doorbell", cmpReady, !modelFull());
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 memReq", memReq, 1'b0);
    chk("R1 irq", irqPulse, 1'b0);
    chk("R1 dbError", dbError, 1'b0);
    chk("R1 ready", cmpReady, 1'b1);
  endtask

  task automatic testBasic();
    configure(32'h1000_0000);
    postOne(16'h0001, 16'h0005, 16'hA001, 15'h0000, 32'hDEAD_BEEF, 0, 0, 0);
    postOne(16'h0003, 16'h0012, 16'h7F02, 15'h2A5C, 32'h1234_5678, 2, 0, 0);
    postOne(16'hFFFF, 16'hFFFF, 16'hFFFF, 15'h7FFF, 32'hFFFF_FFFF, 0, 0, 0);
  endtask

  task automatic testFill();
    for (int i = 0; i < 4; i++)
      postOne(16'(i + 4), 16'(i), 16'(16'h100 + i), 15'(i), 32'(i * 3), i % 2, 0, 0);
    chk("R7 full after DEPTH-1 entries", cmpReady, 1'b0);
  endtask

  task automatic testBadDoorbell();
    ringDb(16'd9);
    ringDb(16'd8);
    chk("R9 head unchanged, still full", cmpReady, 1'b0);
    ringDb(16'd4);
    chk("R9 error stays sticky", dbError, 1'b1);
  endtask

  task automatic testWrap();
    postOne(16'h0020, 16'h0001, 16'h0B07, 15'h0001, 32'hCAFE_0007, 0, 0, 0);
    postOne(16'h0021, 16'h0002, 16'h0B00, 15'h0002, 32'hCAFE_0000, 1, 0, 0);
    chk("R4 phase inverted after wrap", memData[0], 1'b0);
    postOne(16'h0022, 16'h0003, 16'h0B01, 15'h0003, 32'hCAFE_0001, 0, 0, 0);
    postOne(16'h0023, 16'h0004, 16'h0B02, 15'h0004, 32'hCAFE_0002, 0, 0, 0);
    chk("R7 full at tail 3 head 4", cmpReady, 1'b0);
  endtask

  task automatic testCollision();
    ringDb(16'd5);
    postOne(16'h0030, 16'h0009, 16'h0C03, 15'h0010, 32'h5555_AAAA, 1, 1, 16'd7);
    postOne(16'h0031, 16'h000A, 16'h0C04, 15'h0011, 32'hAAAA_5555, 0, 0, 0);
  endtask

  task automatic testReinit();
    configure(32'h2000_0400);
    postOne(16'h0040, 16'h0000, 16'h0D00, 15'h0000, 32'h0BAD_F00D, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rst_n = 1'b1;
    testBasic();
    testFill();
    testBadDoorbell();
    testWrap();
    testCollision();
    testReinit();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule